// File: doc/BRIEF.md
# Multi-Cycle Sequencing Control Unit

This block sequences a 16-bit processor whose instructions and data live in one shared memory. It holds the program counter, the instruction register and a small control-state register. Every cycle it emits a 28-bit control word for the external register file, function unit and memory. The control word is built from the current state, the 7-bit opcode held in the instruction register and the N and Z flags returned by the function unit. The block also steers the memory address through a two-way multiplexer. The address is either the PC, or the value the register file drives on the A bus.

Each instruction starts with a fetch cycle. It then spends one execute cycle, or two execute cycles for multiply and for the register-indirect load. The PC moves only in the last execute cycle of an instruction. As a result, branch offsets and jumps are taken from the address of the instruction being executed. Instruction fields are opcode IR[15:9], DR IR[8:6], SA IR[5:3] and SB IR[2:0].

Top module: `mcc_top`

## Requirements
- R1: A synchronous reset clears the PC to 0 and puts the unit in the fetch state. In the cycle after reset the control word is the fetch word.
- R2: In fetch, the control word has NS=0001 (first execute state), PS=00 and IL=1. All other fields are 0, so MM=0 and the memory address is the PC. At the edge, IR loads from mem_rdata and the PC is held. While IL=0, IR ignores mem_rdata.
- R3: Control word bit layout: NS[27:24], PS[23:22], IL[21], DX[20:17], AX[16:13], BX[12:9], MB[8], FS[7:4], MD[3], RW[2], MM[1], MW[0]. State codes are 0000 for fetch, 0001 for execute-1 and 0010 for execute-2.
- R4: The PS field sets the PC for the next cycle. 00 holds it, 01 adds 1, 10 adds the sign-extended 6-bit offset {IR[8:6],IR[2:0]}, and 11 loads the A-bus value. PC arithmetic wraps modulo 2^16.
- R5: The ALU opcodes are MOVA 0000000, INC 0000001, ADD 0000010, SUB 0000101, DEC 0000110, AND 0001000, OR 0001001, XOR 0001010 and NOT 0001011. Each takes a single execute cycle with DX={0,DR}, AX={0,SA}, BX={0,SB}, FS=opcode[3:0], RW=1, PS=01 and NS=fetch.
- R6: Branch-on-zero 1100000 and branch-on-negative 1100001 set AX={0,SA} and FS=0000. PS is 10 when the tested flag (Z or N respectively) is 1, otherwise 01. Jump 1110000 sets AX={0,SA} and PS=11. None of the three writes a register.
- R7: Multiply 0001100 takes two execute cycles. The first has AX={0,SA}, BX={0,SB}, FS=1100, RW=0, PS=00 and NS=0010. The second adds DX={0,DR} and RW=1, with PS=01 and NS=fetch.
- R8: Register-indirect load 0010001 takes two execute cycles. The first has DX=1000 (scratch R8), AX={0,SA}, MM=1, MD=1, RW=1, PS=00 and NS=0010. The second has DX={0,DR}, AX=1000, FS=0000, MD=0, RW=1, PS=01 and NS=fetch.
- R9: mem_addr equals abus when MM=1 and the PC when MM=0.
- R10: Any other opcode executes in one cycle as a no-op: only NS=fetch and PS=01 are set. MB and MW are 0 in every control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Shared memory read data |
| flag_n | input | 1 | Negative flag from the function unit |
| flag_z | input | 1 | Zero flag from the function unit |
| abus | input | 16 | Register-file A-bus value (jump target, indirect address) |
| mem_addr | output | 16 | Shared memory address |
| pc | output | 16 | Program counter |
| ctrl_word | output | 28 | Control word for the datapath |

## Verification
Two functions land in the same cycle in the final execute state of multiply and of the indirect load: the register write (RW=1 with DX=DR) and the PC increment (PS=01). In the first cycle of the indirect load, a scratch-register write coincides with a memory address taken from the A bus instead of the PC. The bench sweeps all 128 opcodes under all four N/Z combinations, changing abus and mem_rdata between phases. In every phase it compares the whole control word and the memory address with values computed from the requirements. It also compares the PC one edge later against its own arithmetic model.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 7;
    localparam int FLD_W   = 3;
    localparam int RA_W    = 4;
    localparam int FS_W    = 4;
    localparam int OFF_W   = 2 * FLD_W;
    localparam logic [RA_W-1:0] SCRATCH_REG = 4'b1000;

    typedef enum logic [3:0] {
        ST_FETCH = 4'b0000,
        ST_EXEC0 = 4'b0001,
        ST_EXEC1 = 4'b0010
    } mcc_state_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'b00,
        PC_INC  = 2'b01,
        PC_BR   = 2'b10,
        PC_JMP  = 2'b11
    } pc_act_e;

    typedef struct packed {
        logic [3:0]      ns;
        pc_act_e         ps;
        logic            il;
        logic [RA_W-1:0] dx;
        logic [RA_W-1:0] ax;
        logic [RA_W-1:0] bx;
        logic            mb;
        logic [FS_W-1:0] fs;
        logic            md;
        logic            rw;
        logic            mm;
        logic            mw;
    } ctrl_t;

    localparam logic [OPC_W-1:0] OP_MUL = 7'b0001100;
    localparam logic [OPC_W-1:0] OP_LRI = 7'b0010001;
    localparam logic [OPC_W-1:0] OP_BRZ = 7'b1100000;
    localparam logic [OPC_W-1:0] OP_BRN = 7'b1100001;
    localparam logic [OPC_W-1:0] OP_JMP = 7'b1110000;

    function automatic logic is_alu(input logic [OPC_W-1:0] op);
        case (op)
            7'b0000000, 7'b0000001, 7'b0000010, 7'b0000101, 7'b0000110,
            7'b0001000, 7'b0001001, 7'b0001010, 7'b0001011: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mcc_decoder.sv
module mcc_decoder
    import mcc_pkg::*;
(
    input  mcc_state_e         state,
    input  logic [INSTR_W-1:0] ir,
    input  logic               flag_n,
    input  logic               flag_z,
    output ctrl_t              cw
);
    logic [OPC_W-1:0] op;
    logic [RA_W-1:0]  dr_a, sa_a, sb_a;

    assign op   = ir[INSTR_W-1 -: OPC_W];
    assign dr_a = {1'b0, ir[3*FLD_W-1 -: FLD_W]};
    assign sa_a = {1'b0, ir[2*FLD_W-1 -: FLD_W]};
    assign sb_a = {1'b0, ir[FLD_W-1:0]};

    always_comb begin
        cw = '0;
        case (state)
            ST_FETCH: begin
                cw.ns = ST_EXEC0;
                cw.il = 1'b1;
            end
            ST_EXEC0: begin
                cw.ns = ST_FETCH;
                cw.ps = PC_INC;
                if (is_alu(op)) begin
                    cw.dx = dr_a;
                    cw.ax = sa_a;
                    cw.bx = sb_a;
                    cw.fs = op[FS_W-1:0];
                    cw.rw = 1'b1;
                end else if (op == OP_MUL) begin
                    cw.ns = ST_EXEC1;
                    cw.ps = PC_HOLD;
                    cw.ax = sa_a;
                    cw.bx = sb_a;
                    cw.fs = op[FS_W-1:0];
                end else if (op == OP_LRI) begin
                    cw.ns = ST_EXEC1;
                    cw.ps = PC_HOLD;
                    cw.dx = SCRATCH_REG;
                    cw.ax = sa_a;
                    cw.mm = 1'b1;
                    cw.md = 1'b1;
                    cw.rw = 1'b1;
                end else if (op == OP_BRZ) begin
                    cw.ax = sa_a;
                    cw.ps = flag_z ? PC_BR : PC_INC;
                end else if (op == OP_BRN) begin
                    cw.ax = sa_a;
                    cw.ps = flag_n ? PC_BR : PC_INC;
                end else if (op == OP_JMP) begin
                    cw.ax = sa_a;
                    cw.ps = PC_JMP;
                end
            end
            ST_EXEC1: begin
                cw.ns = ST_FETCH;
                cw.ps = PC_INC;
                if (op == OP_MUL) begin
                    cw.dx = dr_a;
                    cw.ax = sa_a;
                    cw.bx = sb_a;
                    cw.fs = op[FS_W-1:0];
                    cw.rw = 1'b1;
                end else if (op == OP_LRI) begin
                    cw.dx = dr_a;
                    cw.ax = SCRATCH_REG;
                    cw.rw = 1'b1;
                end
            end
            default: cw.ns = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_pc.sv
module mcc_pc
    import mcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pc_act_e          act,
    input  logic [OFF_W-1:0] offset,
    input  logic [W-1:0]     jump_val,
    output logic [W-1:0]     pc_q
);
    logic [W-1:0] pc_d;
    logic [W-1:0] off_ext;

    assign off_ext = {{(W-OFF_W){offset[OFF_W-1]}}, offset};

    always_comb begin
        case (act)
            PC_INC:  pc_d = pc_q + W'(1);
            PC_BR:   pc_d = pc_q + off_ext;
            PC_JMP:  pc_d = jump_val;
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    // R4
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        act == PC_HOLD |=> pc_q == $past(pc_q));

    // R4
    pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        act == PC_INC |=> pc_q == $past(pc_q) + W'(1));
endmodule

// File: rtl/mcc_top.sv
module mcc_top
    import mcc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [DATA_W-1:0] abus,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] pc,
    output logic [$bits(ctrl_t)-1:0] ctrl_word
);
    typedef struct packed {
        mcc_state_e         state;
        logic [INSTR_W-1:0] ir;
    } seq_t;

    seq_t  seq_d, seq_q;
    ctrl_t cw;

    mcc_decoder u_dec (
        .state  (seq_q.state),
        .ir     (seq_q.ir),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .cw     (cw)
    );

    mcc_pc #(.W(DATA_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .act      (cw.ps),
        .offset   ({seq_q.ir[3*FLD_W-1 -: FLD_W], seq_q.ir[FLD_W-1:0]}),
        .jump_val (abus),
        .pc_q     (pc)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.state = mcc_state_e'(cw.ns);
        if (cw.il) seq_d.ir = mem_rdata[INSTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_FETCH;
            seq_q.ir    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr  = cw.mm ? abus : pc;
    assign ctrl_word = cw;

    // R2
    fetch_to_exec_chk: assert property (@(posedge clk) disable iff (rst)
        seq_q.state == ST_FETCH |=> seq_q.state == ST_EXEC0);

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cw.il |=> seq_q.ir == $past(seq_q.ir));

    // R7
    exec1_return_chk: assert property (@(posedge clk) disable iff (rst)
        seq_q.state == ST_EXEC1 |=> seq_q.state == ST_FETCH);
endmodule

// File: tb/tb_mcc_top.sv
module tb_mcc_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] mem_rdata;
    logic        flag_n, flag_z;
    logic [15:0] abus;
    logic [15:0] mem_addr, pc;
    logic [27:0] ctrl_word;

    int checks = 0;
    int failures = 0;
    logic [15:0] pc_exp;

    always #5 clk = ~clk;

    mcc_top dut (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .flag_n(flag_n),
        .flag_z(flag_z), .abus(abus), .mem_addr(mem_addr), .pc(pc),
        .ctrl_word(ctrl_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic is_alu_op(input logic [6:0] op);
        return op inside {7'b0000000, 7'b0000001, 7'b0000010, 7'b0000101, 7'b0000110,
                          7'b0001000, 7'b0001001, 7'b0001010, 7'b0001011};
    endfunction

    // expected control word per R2, R3, R5..R8, R10
    function automatic logic [27:0] exp_cw(input int ph, input logic [6:0] op,
            input logic [2:0] dr, input logic [2:0] sa, input logic [2:0] sb,
            input logic n, input logic z);
        logic [3:0] ns = 0, dx = 0, ax = 0, bx = 0, fs = 0;
        logic [1:0] ps = 0;
        logic il = 0, md = 0, rw = 0, mm = 0;
        if (ph == 0) begin
            ns = 4'd1; il = 1'b1;
        end else if (ph == 1) begin
            ns = 4'd0; ps = 2'd1;
            if (is_alu_op(op)) begin
                dx = {1'b0, dr}; ax = {1'b0, sa}; bx = {1'b0, sb}; fs = op[3:0]; rw = 1'b1;
            end else if (op == 7'b0001100) begin
                ns = 4'd2; ps = 2'd0; ax = {1'b0, sa}; bx = {1'b0, sb}; fs = 4'b1100;
            end else if (op == 7'b0010001) begin
                ns = 4'd2; ps = 2'd0; dx = 4'd8; ax = {1'b0, sa}; mm = 1'b1; md = 1'b1; rw = 1'b1;
            end else if (op == 7'b1100000) begin
                ax = {1'b0, sa}; ps = z ? 2'd2 : 2'd1;
            end else if (op == 7'b1100001) begin
                ax = {1'b0, sa}; ps = n ? 2'd2 : 2'd1;
            end else if (op == 7'b1110000) begin
                ax = {1'b0, sa}; ps = 2'd3;
            end
        end else begin
            ns = 4'd0; ps = 2'd1;
            if (op == 7'b0001100) begin
                dx = {1'b0, dr}; ax = {1'b0, sa}; bx = {1'b0, sb}; fs = 4'b1100; rw = 1'b1;
            end else if (op == 7'b0010001) begin
                dx = {1'b0, dr}; ax = 4'd8; rw = 1'b1;
            end
        end
        return {ns, ps, il, dx, ax, bx, 1'b0, fs, md, rw, mm, 1'b0};
    endfunction

    function automatic logic [15:0] next_pc(input logic [15:0] p, input logic [1:0] ps,
            input logic [5:0] off, input logic [15:0] ab);
        case (ps)
            2'd1: return p + 16'd1;
            2'd2: return p + {{10{off[5]}}, off};
            2'd3: return ab;
            default: return p;
        endcase
    endfunction

    function automatic string req_of(input logic [6:0] op);
        if (is_alu_op(op)) return "R5";
        if (op == 7'b0001100) return "R7";
        if (op == 7'b0010001) return "R8";
        if (op inside {7'b1100000, 7'b1100001, 7'b1110000}) return "R6";
        return "R10";
    endfunction

    // called at a negedge while the unit is in fetch
    task automatic run_instr(input logic [6:0] op, input logic [2:0] dr, input logic [2:0] sa,
            input logic [2:0] sb, input logic n, input logic z, input logic [15:0] ab);
        logic [27:0] e;
        logic [15:0] instr = {op, dr, sa, sb};
        string rq = req_of(op);
        mem_rdata = instr; flag_n = n; flag_z = z; abus = ab;
        #1;
        chk("R2 fetch word", ctrl_word, exp_cw(0, op, dr, sa, sb, n, z));
        chk("R9 fetch addr", mem_addr, pc_exp);
        @(posedge clk); @(negedge clk);
        mem_rdata = ~instr;  // R2: IR must ignore this while IL=0
        #1;
        chk("R2 pc held in fetch", pc, pc_exp);
        e = exp_cw(1, op, dr, sa, sb, n, z);
        chk({rq, " exec1 word"}, ctrl_word, e);
        chk("R9 exec addr", mem_addr, e[1] ? ab : pc_exp);
        pc_exp = next_pc(pc_exp, e[23:22], {dr, sb}, ab);
        @(posedge clk); @(negedge clk);
        #1;
        chk({rq, " R4 pc after exec1"}, pc, pc_exp);
        if (e[27:24] == 4'd2) begin
            e = exp_cw(2, op, dr, sa, sb, n, z);
            chk({rq, " exec2 word"}, ctrl_word, e);
            pc_exp = next_pc(pc_exp, e[23:22], {dr, sb}, ab);
            @(posedge clk); @(negedge clk);
            #1;
            chk({rq, " R4 pc after exec2"}, pc, pc_exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; mem_rdata = 16'h0; flag_n = 1'b0; flag_z = 1'b0; abus = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pc_exp = 16'h0;
        #1;
        chk("R1 reset pc", pc, 16'h0);
        chk("R1 reset fetch word", ctrl_word, exp_cw(0, 7'd0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0));
        // R3 field layout exercised by every whole-word compare below
        for (int op = 0; op < 128; op++) begin
            for (int nz = 0; nz < 4; nz++) begin
                run_instr(7'(op), 3'((op * 3 + nz) % 8), 3'((op + 5 * nz) % 8),
                          3'((op * 7 + nz + 2) % 8), nz[1], nz[0],
                          16'(op * 16'h0137 + nz * 16'h1111 + 5));
            end
        end
        // R4 branch with negative offset and wrap, then jump to top of space
        run_instr(7'b1100000, 3'b111, 3'd1, 3'b000, 1'b0, 1'b1, 16'h0);
        run_instr(7'b1110000, 3'd0, 3'd2, 3'd0, 1'b0, 1'b0, 16'hFFFF);
        run_instr(7'b0000001, 3'd1, 3'd1, 3'd1, 1'b0, 1'b0, 16'h0);
        chk("R4 wrap to zero", pc, 16'h0000);
        // R1 reset mid-instruction
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0; #1;
        chk("R1 reset mid-run pc", pc, 16'h0);
        chk("R1 reset mid-run word", ctrl_word, exp_cw(0, 7'd0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule